// File: doc/BRIEF.md
# Ping-pong NTT coefficient memory sequencer

This block sequences coefficient storage for a pipelined constant-geometry number-theoretic transform of length N. It uses one butterfly with two lanes, so two coefficients enter per cycle. It owns two sets of storage. Each set holds an even bank and an odd bank, and every bank is a simple dual-port RAM of N/2 words. Every stage reads its operands from one set and writes its results to the other set. Write-back therefore never lands on an operand that the running stage has not yet read. All log2(N) stages run back to back with no idle cycle between them.

The arithmetic is replaced by a pass-through model with a fixed latency of BF_LAT cycles. Lane 0 carries the even-bank operand and lane 1 the odd-bank operand. A lane selector stage turns the two results of each cycle into one write per bank per cycle. While the block is idle, a host port loads a set before a run and reads the result out afterwards.

Top module: `ntt_pp_mem_ctrl`

## Requirements
- R1: After reset the outputs are `busy`=0, `done`=0, `rd_set`=0 and `stage_idx`=0.
- R2: A `start` pulse seen while idle launches a run, and `busy` is 1 in the first cycle after that edge. `busy` is 0 in the cycle where `done` is 1.
- R3: `done` is 1 for exactly one cycle. That cycle is the (log2(N)·N/2 + BF_LAT + 4)-th cycle after the edge that sampled `start`, counting the first cycle after that edge as 1. The count is 37 at the defaults.
- R4: Stage s (0-based) reads set s mod 2, and `rd_set` shows that set while the stage issues. Each stage issues for exactly N/2 cycles, and `rd_set` toggles at every stage boundary.
- R5: In stage 0, issue cycle t reads word N/2-1-t of both banks. Lane 0 takes the word from bank 0 and lane 1 the word from bank 1.
- R6: In every later stage, issue cycle t reads word t of both banks.
- R7: The pair issued in cycle t of a stage goes to logical positions t (from lane 0) and t+N/2 (from lane 1) of the other set. Position p is stored in bank p mod 2 at word p div 2.
- R8: Once `done` has been seen, the result is held in set log2(N) mod 2. A host read presented in one cycle returns its word on `host_rd_data` in the following cycle.
- R9: Host writes and further `start` pulses have no effect while `busy` is 1.
- R10: A `start` given in the cycle where `done` is 1 is accepted. The new run transforms the previous result with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a run when idle |
| busy | output | 1 | Run in progress, including write drain |
| done | output | 1 | One-cycle pulse after the last write commits |
| rd_set | output | 1 | Set the current stage reads from |
| stage_idx | output | STW | Index of the stage currently issuing |
| host_wr_en | input | 1 | Host write strobe, used only when idle |
| host_wr_set | input | 1 | Set selected for the host write |
| host_wr_bank | input | 1 | Bank selected for the host write (0 even, 1 odd) |
| host_wr_addr | input | AW | Word address for the host write |
| host_wr_data | input | W | Data for the host write |
| host_rd_set | input | 1 | Set selected for the host read |
| host_rd_bank | input | 1 | Bank selected for the host read |
| host_rd_addr | input | AW | Word address for the host read |
| host_rd_data | output | W | Host read data, one cycle after the address |

## Verification
The hardest situation to reach is the read-after-write race at a stage boundary. There, the next stage reads words of a set whose write-back from the previous stage is still in flight. Every run chains four stages with no gap, so each boundary exercises this race, and one wrong word on the way corrupts the final permutation. The same runs also show whether a write was dropped: the values loaded are all distinct, so the bench can compare the whole result word for word against a model of the addressing. One run injects a host write into a word that stage 0 has not yet read and also pulses `start` mid-run; a correct result and unchanged timing show both were ignored. One run restarts in the very `done` cycle to cover the idle-to-busy hand-over.

// File: rtl/ntt_pp_pkg.sv
// Shared definitions for the ping-pong NTT coefficient memory sequencer.
// Assumes: N is a power of two and at least 16.
package ntt_pp_pkg;
    // Bank identifiers: bank 0 holds even positions after stage 0
    localparam logic BANK_EVEN = 1'b0;
    localparam logic BANK_ODD  = 1'b1;
    // Number of storage sets used for ping-pong operation
    localparam int NUM_SETS    = 2;
    localparam int NUM_BANKS   = 2;
endpackage

// File: rtl/ntt_pp_sdp_ram.sv
// Behavioural simple dual-port RAM: one registered read, one write per cycle.
// Assumes: a read and a write to the same word in one cycle returns old data.
module ntt_pp_sdp_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Write port and registered read port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/ntt_pp_seq.sv
// Stage sequencer: walks log2(N) stages of N/2 issue cycles each, with no gap.
// It produces the read address, the source set and the write-back tag.
// Assumes: launch is only asserted while the whole block is idle.
module ntt_pp_seq #(
    parameter int N      = 16,
    localparam int HALF   = N / 2,
    localparam int AW     = $clog2(HALF),
    localparam int STAGES = $clog2(N),
    localparam int STW    = $clog2(STAGES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    output logic           issue_vld,
    output logic [AW-1:0]  rd_addr,
    output logic           rd_set,
    output logic [STW-1:0] stage_idx,
    output logic [AW-1:0]  tag_t,
    output logic           tag_dst,
    output logic           tag_last
);
    localparam logic [AW-1:0]  T_LAST = AW'(HALF - 1);
    localparam logic [STW-1:0] S_LAST = STW'(STAGES - 1);

    logic [AW-1:0]  t_q;
    logic [STW-1:0] stage_q;
    logic           set_q;
    logic           run_q;

    // Issue counter, stage counter and ping-pong set toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            t_q     <= '0;
            stage_q <= '0;
            set_q   <= 1'b0;
        end else if (launch) begin
            run_q   <= 1'b1;
            t_q     <= '0;
            stage_q <= '0;
            set_q   <= 1'b0;
        end else if (run_q) begin
            if (t_q == T_LAST) begin
                t_q <= '0;
                if (stage_q == S_LAST) begin
                    run_q <= 1'b0;
                end else begin
                    stage_q <= stage_q + 1'b1;
                    set_q   <= ~set_q;
                end
            end else begin
                t_q <= t_q + 1'b1;
            end
        end
    end

    // Stage 0 walks the banks downwards, later stages walk upwards
    always_comb begin
        rd_addr   = (stage_q == '0) ? (T_LAST - t_q) : t_q;
        issue_vld = run_q;
        rd_set    = set_q;
        stage_idx = stage_q;
        tag_t     = t_q;
        tag_dst   = ~set_q;
        tag_last  = run_q && (stage_q == S_LAST) && (t_q == T_LAST);
    end
endmodule

// File: rtl/ntt_pp_bfly_model.sv
// Fixed-latency stand-in for the butterfly: both lanes and a sideband tag
// pass through LAT register stages unchanged. LAT = 0 gives a wire.
module ntt_pp_bfly_model #(
    parameter int W    = 16,
    parameter int TAGW = 6,
    parameter int LAT  = 1,
    localparam int PW  = TAGW + 2 * W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    in_lane0,
    input  logic [W-1:0]    in_lane1,
    input  logic [TAGW-1:0] in_tag,
    output logic [W-1:0]    out_lane0,
    output logic [W-1:0]    out_lane1,
    output logic [TAGW-1:0] out_tag
);
    generate
        if (LAT == 0) begin : g_wire
            assign out_lane0 = in_lane0;
            assign out_lane1 = in_lane1;
            assign out_tag   = in_tag;
        end else begin : g_pipe
            logic [PW-1:0] pipe [LAT];
            // Shift the packed lanes and tag down the latency chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < LAT; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= {in_tag, in_lane1, in_lane0};
                    for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign {out_tag, out_lane1, out_lane0} = pipe[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/ntt_pp_lane_sel.sv
// Lane selector: both results of issue cycle t go to positions of parity t,
// which would be two writes into one bank. Holding one result back one cycle
// gives each bank exactly one write per cycle. Its outputs are registered.
// Assumes: valid results arrive in even/odd pairs with no gap inside a stage.
module ntt_pp_lane_sel #(
    parameter int W       = 16,
    parameter int AW      = 3,
    parameter int QUARTER = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic          last,
    input  logic          dst,
    input  logic [AW-1:0] t,
    input  logic [W-1:0]  d0,
    input  logic [W-1:0]  d1,
    output logic          wa_en,
    output logic          wa_set,
    output logic [AW-1:0] wa_addr,
    output logic [W-1:0]  wa_data,
    output logic          wb_en,
    output logic          wb_set,
    output logic [AW-1:0] wb_addr,
    output logic [W-1:0]  wb_data,
    output logic          wr_done
);
    logic [AW-1:0] lo_addr, hi_addr;
    logic          odd_in, even_in;
    logic [W-1:0]  he_data, ho_data;
    logic [AW-1:0] he_addr, ho_addr;
    logic          he_set, ho_set, ho_pend, ho_last;

    // Position decode: t maps to word t/2, t+N/2 maps to word t/2+N/4
    always_comb begin
        lo_addr = t >> 1;
        hi_addr = lo_addr + AW'(QUARTER);
        odd_in  = vld && t[0];
        even_in = vld && !t[0];
    end

    // Route direct and held results to the two bank write ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wa_en   <= 1'b0;  wa_set  <= 1'b0;  wa_addr <= '0;  wa_data <= '0;
            wb_en   <= 1'b0;  wb_set  <= 1'b0;  wb_addr <= '0;  wb_data <= '0;
            wr_done <= 1'b0;
            he_data <= '0;    he_addr <= '0;    he_set  <= 1'b0;
            ho_data <= '0;    ho_addr <= '0;    ho_set  <= 1'b0;
            ho_pend <= 1'b0;  ho_last <= 1'b0;
        end else begin
            wa_en   <= vld;
            wa_set  <= odd_in ? he_set  : dst;
            wa_addr <= odd_in ? he_addr : lo_addr;
            wa_data <= odd_in ? he_data : d0;
            wb_en   <= odd_in || ho_pend;
            wb_set  <= odd_in ? dst     : ho_set;
            wb_addr <= odd_in ? lo_addr : ho_addr;
            wb_data <= odd_in ? d0      : ho_data;
            wr_done <= ho_pend && ho_last && !odd_in;
            if (even_in) begin
                he_data <= d1;
                he_addr <= hi_addr;
                he_set  <= dst;
            end
            if (odd_in) begin
                ho_data <= d1;
                ho_addr <= hi_addr;
                ho_set  <= dst;
                ho_pend <= 1'b1;
                ho_last <= last;
            end else begin
                ho_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ntt_pp_mem_ctrl.sv
// Top level: sequencer, four banks (two sets of two), butterfly model and
// lane selector. Each stage reads one set and writes the other. The host
// port loads and reads the banks while the block is idle.
// Assumes: BF_LAT < N/4 - 2, so write-back lands before the next stage reads.
module ntt_pp_mem_ctrl #(
    parameter int N      = 16,
    parameter int W      = 16,
    parameter int BF_LAT = 1,
    localparam int HALF    = N / 2,
    localparam int QUARTER = N / 4,
    localparam int AW      = $clog2(HALF),
    localparam int STAGES  = $clog2(N),
    localparam int STW     = $clog2(STAGES),
    localparam int TAGW    = AW + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic           rd_set,
    output logic [STW-1:0] stage_idx,
    input  logic           host_wr_en,
    input  logic           host_wr_set,
    input  logic           host_wr_bank,
    input  logic [AW-1:0]  host_wr_addr,
    input  logic [W-1:0]   host_wr_data,
    input  logic           host_rd_set,
    input  logic           host_rd_bank,
    input  logic [AW-1:0]  host_rd_addr,
    output logic [W-1:0]   host_rd_data
);
    import ntt_pp_pkg::*;

    logic          launch;
    logic          issue_vld;
    logic [AW-1:0] seq_rd_addr;
    logic [AW-1:0] tag_t;
    logic          tag_dst, tag_last;

    logic            tq_vld, tq_last, tq_dst, src_set_q;
    logic [AW-1:0]   tq_t;
    logic            hrd_set_q, hrd_bank_q;
    logic [W-1:0]    lane0, lane1, bo0, bo1;
    logic [TAGW-1:0] bo_tag;

    logic          wa_en, wa_set, wb_en, wb_set, sel_done;
    logic [AW-1:0] wa_addr, wb_addr;
    logic [W-1:0]  wa_data, wb_data;

    logic          ram_we    [NUM_SETS][NUM_BANKS];
    logic [AW-1:0] ram_waddr [NUM_SETS][NUM_BANKS];
    logic [W-1:0]  ram_wdata [NUM_SETS][NUM_BANKS];
    logic [AW-1:0] ram_raddr;
    logic [W-1:0]  ram_rdata [NUM_SETS][NUM_BANKS];

    assign launch = start && !busy;

    ntt_pp_seq #(.N(N)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .issue_vld(issue_vld), .rd_addr(seq_rd_addr), .rd_set(rd_set),
        .stage_idx(stage_idx), .tag_t(tag_t), .tag_dst(tag_dst),
        .tag_last(tag_last)
    );

    // Run state: raised by launch, dropped when the final write commits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= sel_done;
            if (launch)        busy <= 1'b1;
            else if (sel_done) busy <= 1'b0;
        end
    end

    // Align the issue tag and the read selects with the registered RAM output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tq_vld <= 1'b0; tq_last <= 1'b0; tq_dst <= 1'b0; tq_t <= '0;
            src_set_q <= 1'b0; hrd_set_q <= 1'b0; hrd_bank_q <= 1'b0;
        end else begin
            tq_vld     <= issue_vld;
            tq_last    <= tag_last;
            tq_dst     <= tag_dst;
            tq_t       <= tag_t;
            src_set_q  <= rd_set;
            hrd_set_q  <= host_rd_set;
            hrd_bank_q <= host_rd_bank;
        end
    end

    assign ram_raddr = busy ? seq_rd_addr : host_rd_addr;

    genvar gs, gb;
    generate
        for (gs = 0; gs < NUM_SETS; gs++) begin : g_set
            for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
                logic host_hit, port_en, port_set;
                assign host_hit = !busy && host_wr_en &&
                                  (host_wr_set == gs[0]) && (host_wr_bank == gb[0]);
                if (gb == 0) begin : g_even
                    assign port_en  = wa_en;
                    assign port_set = wa_set;
                    assign ram_waddr[gs][gb] = busy ? wa_addr : host_wr_addr;
                    assign ram_wdata[gs][gb] = busy ? wa_data : host_wr_data;
                end else begin : g_odd
                    assign port_en  = wb_en;
                    assign port_set = wb_set;
                    assign ram_waddr[gs][gb] = busy ? wb_addr : host_wr_addr;
                    assign ram_wdata[gs][gb] = busy ? wb_data : host_wr_data;
                end
                assign ram_we[gs][gb] = busy ? (port_en && (port_set == gs[0])) : host_hit;

                ntt_pp_sdp_ram #(.W(W), .DEPTH(HALF)) u_ram (
                    .clk(clk), .we(ram_we[gs][gb]), .waddr(ram_waddr[gs][gb]),
                    .wdata(ram_wdata[gs][gb]), .raddr(ram_raddr),
                    .rdata(ram_rdata[gs][gb])
                );
            end
        end
    endgenerate

    // Operand and host read-data selection by the registered set/bank
    always_comb begin
        lane0        = src_set_q ? ram_rdata[1][BANK_EVEN] : ram_rdata[0][BANK_EVEN];
        lane1        = src_set_q ? ram_rdata[1][BANK_ODD]  : ram_rdata[0][BANK_ODD];
        host_rd_data = ram_rdata[hrd_set_q][hrd_bank_q];
    end

    ntt_pp_bfly_model #(.W(W), .TAGW(TAGW), .LAT(BF_LAT)) u_bfly (
        .clk(clk), .rst_n(rst_n),
        .in_lane0(lane0), .in_lane1(lane1),
        .in_tag({tq_vld, tq_last, tq_dst, tq_t}),
        .out_lane0(bo0), .out_lane1(bo1), .out_tag(bo_tag)
    );

    ntt_pp_lane_sel #(.W(W), .AW(AW), .QUARTER(QUARTER)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .vld(bo_tag[TAGW-1]), .last(bo_tag[TAGW-2]), .dst(bo_tag[TAGW-3]),
        .t(bo_tag[AW-1:0]), .d0(bo0), .d1(bo1),
        .wa_en(wa_en), .wa_set(wa_set), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_set(wb_set), .wb_addr(wb_addr), .wb_data(wb_data),
        .wr_done(sel_done)
    );
endmodule

// File: rtl/ntt_pp_mem_ctrl_chk.sv
// Property checker for ntt_pp_mem_ctrl, attached by bind below.
module ntt_pp_mem_ctrl_chk #(
    parameter int N   = 16,
    parameter int AW  = 3,
    parameter int STW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           rd_set,
    input logic [STW-1:0] stage_idx,
    input logic           issue_vld,
    input logic [AW-1:0]  seq_rd_addr
);
    localparam logic [AW-1:0] TOP_ADDR = AW'(N / 2 - 1);

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    issue_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> busy);

    // R4
    set_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && $past(issue_vld) && (stage_idx != $past(stage_idx)))
        |-> (rd_set != $past(rd_set)));

    // R5
    rev_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(issue_vld) |-> (seq_rd_addr == TOP_ADDR));

    // R6
    seq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && $past(issue_vld) && (stage_idx != $past(stage_idx)))
        |-> (seq_rd_addr == '0));
endmodule

bind ntt_pp_mem_ctrl ntt_pp_mem_ctrl_chk #(.N(N), .AW(AW), .STW(STW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_set(rd_set),
    .stage_idx(stage_idx), .issue_vld(issue_vld), .seq_rd_addr(seq_rd_addr)
);

// File: tb/ntt_pp_mem_ctrl_bench.sv
module ntt_pp_mem_ctrl_bench;
    localparam int N = 16, W = 16, LAT = 1;
    localparam int HALF = N / 2, AW = $clog2(HALF), STAGES = $clog2(N);
    localparam int STW = $clog2(STAGES);
    localparam int LATENCY = STAGES * HALF + LAT + 3;
    localparam int NVEC = 4;
    localparam logic [15:0] VEC_SEED [NVEC] = '{16'h0100, 16'h1000, 16'h7F00, 16'hC350};
    localparam logic [15:0] VEC_STEP [NVEC] = '{16'h0001, 16'h0011, 16'h0103, 16'h0FF1};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, rd_set;
    logic [STW-1:0] stage_idx;
    logic host_wr_en = 1'b0, host_wr_set = 1'b0, host_wr_bank = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic [W-1:0] host_wr_data = '0;
    logic host_rd_set = 1'b0, host_rd_bank = 1'b0;
    logic [AW-1:0] host_rd_addr = '0;
    logic [W-1:0] host_rd_data;

    int tests = 0, fails = 0;
    int unsigned mdl [2][2][HALF];

    always #5 clk = ~clk;

    ntt_pp_mem_ctrl #(.N(N), .W(W), .BF_LAT(LAT)) u_ntt_pp_mem_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .rd_set(rd_set), .stage_idx(stage_idx),
        .host_wr_en(host_wr_en), .host_wr_set(host_wr_set),
        .host_wr_bank(host_wr_bank), .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data), .host_rd_set(host_rd_set),
        .host_rd_bank(host_rd_bank), .host_rd_addr(host_rd_addr),
        .host_rd_data(host_rd_data)
    );

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic host_load(int s, int b, int a, int unsigned v);
        host_wr_en = 1'b1; host_wr_set = s[0]; host_wr_bank = b[0];
        host_wr_addr = AW'(a); host_wr_data = W'(v);
        @(posedge clk); #1;
        host_wr_en = 1'b0;
        mdl[s][b][a] = v & 32'hFFFF;
    endtask

    // Expected result of one run, from the addressing rules R5, R6, R7
    task automatic model_run();
        for (int s = 0; s < STAGES; s++) begin
            int src = s % 2;
            for (int t = 0; t < HALF; t++) begin
                int r = (s == 0) ? HALF - 1 - t : t;
                int p0 = t, p1 = t + HALF;
                mdl[1-src][p0%2][p0/2] = mdl[src][0][r];
                mdl[1-src][p1%2][p1/2] = mdl[src][1][r];
            end
        end
    endtask

    task automatic pulse_start();
        start = 1'b1; @(posedge clk); #1; start = 1'b0;
    endtask

    // Entered at the first cycle after the edge that sampled start
    task automatic wait_run(string lbl, bit intrude, bit chain);
        int k = 0, done_k = -1;
        chk({"R2 busy after start ", lbl}, busy, 1);
        while (k < 200 && done_k < 0) begin
            @(posedge clk); k++; #1;
            if (intrude && k == 5) begin
                host_wr_en = 1'b1; host_wr_set = 1'b0; host_wr_bank = 1'b0;
                host_wr_addr = '0; host_wr_data = 16'hBEEF; start = 1'b1;
            end
            if (intrude && k == 7) begin
                host_wr_en = 1'b0; start = 1'b0;
            end
            if (k < STAGES * HALF && (k % HALF) == HALF / 2) begin
                chk({"R4 rd_set ", lbl}, rd_set, (k / HALF) % 2);
                chk({"R4 stage_idx ", lbl}, stage_idx, k / HALF);
            end
            if (done) done_k = k;
        end
        chk({"R3 done cycle ", lbl}, done_k, LATENCY);
        chk({"R2 busy low at done ", lbl}, busy, 0);
        model_run();
        if (chain) begin
            start = 1'b1; @(posedge clk); #1; start = 1'b0;
        end else begin
            @(posedge clk); #1;
        end
        chk({"R3 done single ", lbl}, done, 0);
    endtask

    task automatic readout(string lbl);
        int fs = STAGES % 2;
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < HALF; a++) begin
                host_rd_set = fs[0]; host_rd_bank = b[0]; host_rd_addr = AW'(a);
                @(posedge clk); #1;
                chk({"R5 R6 R7 R8 word ", lbl}, host_rd_data, mdl[fs][b][a]);
            end
    endtask

    task automatic load_vec(int unsigned seed, int unsigned step);
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < HALF; a++) begin
                host_load(0, b, a, seed + step * (b * HALF + a));
                host_load(1, b, a, 32'hA5A5 ^ (b * HALF + a));
            end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 rd_set", rd_set, 0);
        chk("R1 stage_idx", stage_idx, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // Table-driven runs
        for (int i = 0; i < NVEC; i++) begin
            load_vec(VEC_SEED[i], VEC_STEP[i]);
            pulse_start();
            wait_run("table", 1'b0, 1'b0);
            readout("table");
        end

        // R9: host write and start during a run are ignored
        load_vec(32'h2000, 32'h0007);
        pulse_start();
        wait_run("R9 intrude", 1'b1, 1'b0);
        readout("R9 intrude");

        // R10: restart in the done cycle, second run transforms the first result
        load_vec(32'h3300, 32'h0023);
        pulse_start();
        wait_run("R10 first", 1'b0, 1'b1);
        wait_run("R10 second", 1'b0, 1'b0);
        readout("R10 second");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule